// File: doc/BRIEF.md
# SDRAM Power-Down Entry and Exit Controller

This block sits between an SDRAM access scheduler and the memory pins. It decides when the clock-enable line may drop and when it must come back up. When the low-power field selects power-down, the block waits until no access is in flight. It then counts a selectable number of idle cycles and lowers CKE. While CKE is low, every command that reaches the device is forced to NOP.

The device does not refresh itself while it is powered down, so a refresh-due pulse wakes it just as an access request does. A minimum time in power-down applies to the DDR-class memories, and the exit delay depends on the memory family. After wake-up, refresh is served before any access. The scheduler sees an ordinary valid/ready handshake. `acc_req` is the valid: once raised it must stay high, with `cmd_in` stable, until a cycle in which `sched_ready` is also high. `sched_ready` is the back-pressure. It is low while the device sleeps or wakes, while an access or refresh is in flight, and while a refresh is pending.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: CKE only falls while `lp_mode` equals 2'b10. With any other value CKE stays high indefinitely.
- R2: With `idle_sel` 2'b00, or the reserved 2'b11, CKE goes low on the first rising edge at which the block is idle: not busy, no request, no refresh pending.
- R3: With `idle_sel` 2'b01, CKE goes low on the 65th rising edge after the edge that samples `acc_done`. With 2'b10 it goes low on the 129th such edge (64 or 128 idle cycles counted first).
- R4: A new access accepted during the idle countdown restarts it. The full count applies again from that access's `acc_done`.
- R5: While CKE is low, and during the exit delay, `cmd_out` is NOP (4'b0111) and `sched_ready` is low.
- R6: Once CKE is low it stays low for at least TCKE cycles (default 3) for `mem_kind` 2'b10 (low-power DDR) and 2'b11 (DDR2). For 2'b00 (SDR) and 2'b01 (low-power SDR) the minimum is 1 cycle.
- R7: On exit, CKE rises together with a NOP. SDR types hold NOP for 1 cycle before `sched_ready` may rise. DDR types hold it for TXP cycles (default 2).
- R8: `refresh_due` wakes a powered-down device. After wake-up, `refresh_grant` is raised before any access is accepted. `sched_ready` is low in every cycle `refresh_grant` is high.
- R9: Out of reset, CKE is high, `refresh_grant` is low and `sched_ready` is high. While CKE is high and no exit is in progress, `cmd_out` equals `cmd_in`.
- R10: An accepted access (`acc_req` and `sched_ready` both high) or a refresh grant makes the block busy until `acc_done`. While busy, CKE does not fall and `sched_ready` stays low.
- R11: Changing `lp_mode` away from 2'b10 while powered down wakes the device. CKE is high after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_mode | input | 2 | Low-power selection; 2'b10 selects power-down |
| idle_sel | input | 2 | Idle timeout: 00/11 none, 01 64 cycles, 10 128 cycles |
| mem_kind | input | 2 | 00 SDR, 01 low-power SDR, 10 low-power DDR, 11 DDR2 |
| acc_req | input | 1 | Access request (valid), held until accepted |
| sched_ready | output | 1 | Access may be accepted this cycle (ready) |
| cmd_in | input | 4 | Command from the scheduler |
| refresh_due | input | 1 | One-cycle pulse: a refresh must be performed |
| acc_done | input | 1 | Pulse: the access or refresh in flight has completed |
| cke | output | 1 | Clock enable to the memory |
| cmd_out | output | 4 | Command to the memory (pass-through or NOP) |
| refresh_grant | output | 1 | Scheduler may issue the pending refresh now |

## Verification
The sharpest overlap is a refresh-due pulse and an access request arriving in the same cycle while the device is powered down. Both are wake causes and both compete for the first active cycle. The bench raises the two together on one sampling point and follows the outputs cycle by cycle. It expects the grant to appear first, with ready held low in that cycle. An access must then be accepted only after the refresh completes. A second overlap comes from re-issuing an access partway through the idle countdown. The bench checks that the entry delay counts again in full from the later completion, with no carry-over from the earlier one.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_DOWN   = 2'd1,
    ST_WAKE   = 2'd2
  } pd_state_t;

  localparam logic [1:0] LP_POWERDOWN = 2'b10;
  localparam logic [3:0] CMD_NOP      = 4'b0111;

  localparam logic [1:0] MEM_SDR   = 2'b00;
  localparam logic [1:0] MEM_LPSDR = 2'b01;
  localparam logic [1:0] MEM_LPDDR = 2'b10;
  localparam logic [1:0] MEM_DDR2  = 2'b11;

endpackage

// File: rtl/sdram_pd_idle_timer.sv
module sdram_pd_idle_timer #(
  parameter int W        = 8,
  parameter int SHORT_LIM = 64,
  parameter int LONG_LIM  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       expired
);

  localparam logic [W-1:0] LIM_S = W'(SHORT_LIM);
  localparam logic [W-1:0] LIM_L = W'(LONG_LIM);

  logic [W-1:0] cnt;
  logic [W-1:0] limit;

  always_comb begin
    case (sel)
      2'b01:   limit = LIM_S;
      2'b10:   limit = LIM_L;
      default: limit = '0;   // 00 and reserved 11: enter at once
    endcase
  end

  assign expired = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // counter saturates at the active limit, never beyond the longest one
  p_idle_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM_L);

endmodule

// File: rtl/sdram_pd_span.sv
module sdram_pd_span #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         reached
);

  logic [W-1:0] cnt;

  // reached in the limit-th cycle of a run (limit 0 behaves as 1)
  assign reached = run && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!reached) cnt <= cnt + 1'b1;
  end

  p_span_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (cnt < limit));

endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
  import sdram_pd_pkg::*;
#(
  parameter int TCKE      = 3,
  parameter int TXP       = 2,
  parameter int SHORT_LIM = 64,
  parameter int LONG_LIM  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lp_mode,
  input  logic [1:0] idle_sel,
  input  logic [1:0] mem_kind,
  input  logic       acc_req,
  output logic       sched_ready,
  input  logic [3:0] cmd_in,
  input  logic       refresh_due,
  input  logic       acc_done,
  output logic       cke,
  output logic [3:0] cmd_out,
  output logic       refresh_grant
);

  localparam int IDLE_W = $clog2(LONG_LIM + 1);
  localparam int SPAN_W = $clog2(((TCKE > TXP) ? TCKE : TXP) + 2);

  pd_state_t st, st_n;
  logic busy, pend;
  logic pd_en, hs, idle_clr, idle_expired, go_down, wake;
  logic res_reached, exit_reached;
  logic [SPAN_W-1:0] res_lim, exit_lim;

  assign pd_en = (lp_mode == LP_POWERDOWN);

  // family-dependent residency and exit spans
  always_comb begin
    case (mem_kind)
      MEM_LPDDR, MEM_DDR2: begin
        res_lim  = SPAN_W'(TCKE);
        exit_lim = SPAN_W'(TXP);
      end
      default: begin   // MEM_SDR, MEM_LPSDR
        res_lim  = SPAN_W'(1);
        exit_lim = SPAN_W'(1);
      end
    endcase
  end

  // scheduler-facing handshake: refresh has priority over access
  assign sched_ready   = (st == ST_ACTIVE) && !busy && !pend;
  assign refresh_grant = (st == ST_ACTIVE) && !busy && pend;
  assign hs            = acc_req && sched_ready;

  assign cke     = (st != ST_DOWN);
  assign cmd_out = (st == ST_ACTIVE) ? cmd_in : CMD_NOP;

  assign idle_clr = (st != ST_ACTIVE) || busy || pend || acc_req || refresh_due;
  assign go_down  = pd_en && !idle_clr && idle_expired;
  assign wake     = acc_req || pend || refresh_due || !pd_en;

  sdram_pd_idle_timer #(
    .W(IDLE_W), .SHORT_LIM(SHORT_LIM), .LONG_LIM(LONG_LIM)
  ) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .sel(idle_sel),
    .expired(idle_expired)
  );

  sdram_pd_span #(.W(SPAN_W)) u_resid (
    .clk(clk), .rst_n(rst_n), .run(st == ST_DOWN), .limit(res_lim),
    .reached(res_reached)
  );

  sdram_pd_span #(.W(SPAN_W)) u_exit (
    .clk(clk), .rst_n(rst_n), .run(st == ST_WAKE), .limit(exit_lim),
    .reached(exit_reached)
  );

  always_comb begin
    st_n = st;
    case (st)
      ST_ACTIVE: if (go_down)             st_n = ST_DOWN;
      ST_DOWN:   if (wake && res_reached) st_n = ST_WAKE;
      ST_WAKE:   if (exit_reached)        st_n = ST_ACTIVE;
      default:                            st_n = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_ACTIVE;
      busy <= 1'b0;
      pend <= 1'b0;
    end else begin
      st   <= st_n;
      busy <= busy ? !acc_done : (hs || refresh_grant);
      pend <= refresh_due || (pend && !refresh_grant);
    end
  end

  p_nop_asleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd_out == CMD_NOP) && !sched_ready);

  p_fall_needs_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ($past(lp_mode) == LP_POWERDOWN));

  p_no_fall_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> !$past(busy));

  p_grant_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_grant |-> !sched_ready);

  p_wake_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd_out == CMD_NOP) && !sched_ready);

endmodule

// File: tb/sdram_pd_ctrl_test.sv
module sdram_pd_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] lp_mode, idle_sel, mem_kind;
  logic       acc_req, refresh_due, acc_done;
  logic [3:0] cmd_in;
  logic       sched_ready, cke, refresh_grant;
  logic [3:0] cmd_out;

  int total = 0;
  int bad   = 0;

  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] ACT = 4'b0011;

  // {mem_kind, idle_sel, entry edges, residency cycles, exit cycles}
  localparam logic [19:0] VEC [6] = '{
    {2'b00, 2'b00, 8'd1,   4'd1, 4'd1},
    {2'b01, 2'b11, 8'd1,   4'd1, 4'd1},
    {2'b10, 2'b01, 8'd65,  4'd3, 4'd2},
    {2'b11, 2'b10, 8'd129, 4'd3, 4'd2},
    {2'b00, 2'b01, 8'd65,  4'd1, 4'd1},
    {2'b11, 2'b00, 8'd1,   4'd3, 4'd2}
  };

  always #2.5 clk = ~clk;   // 200 MHz

  sdram_pd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .idle_sel(idle_sel),
    .mem_kind(mem_kind), .acc_req(acc_req), .sched_ready(sched_ready),
    .cmd_in(cmd_in), .refresh_due(refresh_due), .acc_done(acc_done),
    .cke(cke), .cmd_out(cmd_out), .refresh_grant(refresh_grant)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_access();
    acc_req = 1'b1;
    while (!sched_ready) @(negedge clk);
    @(negedge clk);
    acc_req  = 1'b0;
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
  endtask

  task automatic wait_low(output int n);
    n = 0;
    while (cke && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, m, q;
    bit nop_ok;
    rst_n = 1'b0; lp_mode = 2'b10; idle_sel = 2'b00; mem_kind = 2'b00;
    acc_req = 1'b0; refresh_due = 1'b0; acc_done = 1'b0; cmd_in = ACT;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(cke == 1'b1, "R9 reset cke", int'(cke), 1);
    chk(sched_ready == 1'b1 && refresh_grant == 1'b0, "R9 reset ready/grant",
        int'({sched_ready, refresh_grant}), 2);
    chk(cmd_out == ACT, "R9 pass-through", int'(cmd_out), int'(ACT));
    rst_n = 1'b1;

    // table walk: R2 R3 R5 R6 R7
    for (int i = 0; i < 6; i++) begin
      mem_kind = VEC[i][19:18];
      idle_sel = VEC[i][17:16];
      do_access();
      wait_low(n);
      chk(n == int'(VEC[i][15:8]), "R2/R3 entry delay", n, int'(VEC[i][15:8]));
      acc_req = 1'b1;
      m = 0;
      nop_ok = 1'b1;
      while (!cke && m < 50) begin
        if (cmd_out != NOP || sched_ready) nop_ok = 1'b0;
        @(negedge clk);
        m++;
      end
      chk(m == int'(VEC[i][7:4]), "R6 residency", m, int'(VEC[i][7:4]));
      q = 0;
      while (!sched_ready && q < 50) begin
        if (cmd_out != NOP) nop_ok = 1'b0;
        @(negedge clk);
        q++;
      end
      chk(q == int'(VEC[i][3:0]), "R7 exit delay", q, int'(VEC[i][3:0]));
      chk(nop_ok, "R5 NOP while low or waking", int'(nop_ok), 1);
      chk(cmd_out == ACT, "R9 pass-through after wake", int'(cmd_out), int'(ACT));
      @(negedge clk);
      acc_req  = 1'b0;
      acc_done = 1'b1;
      @(negedge clk);
      acc_done = 1'b0;
    end

    // R4: countdown restarted by an access in the middle of it
    mem_kind = 2'b00; idle_sel = 2'b01;
    do_access();
    repeat (30) @(negedge clk);
    chk(cke == 1'b1, "R4 still high mid-countdown", int'(cke), 1);
    do_access();
    wait_low(n);
    chk(n == 65, "R4 restarted countdown", n, 65);

    // R11: leaving power-down mode wakes the device
    @(negedge clk);
    lp_mode = 2'b00;
    @(negedge clk);
    chk(cke == 1'b1, "R11 wake on mode change", int'(cke), 1);
    // R1: other modes never drop CKE
    n = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (!cke) n++;
    end
    chk(n == 0, "R1 no entry outside power-down", n, 0);

    // R8 + R10: refresh while awake, busy until done
    refresh_due = 1'b1;
    @(negedge clk);
    refresh_due = 1'b0;
    chk(refresh_grant && !sched_ready, "R8 grant while awake",
        int'({refresh_grant, sched_ready}), 2);
    @(negedge clk);
    chk(!refresh_grant && !sched_ready, "R10 busy after grant",
        int'({refresh_grant, sched_ready}), 0);
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
    chk(sched_ready == 1'b1, "R10 ready after done", int'(sched_ready), 1);

    // R8 collision: refresh and access wake a sleeping device together
    lp_mode = 2'b10; idle_sel = 2'b00; mem_kind = 2'b00;
    wait_low(n);
    chk(cke == 1'b0, "R2 asleep before collision", int'(cke), 0);
    refresh_due = 1'b1;
    acc_req     = 1'b1;
    @(negedge clk);
    refresh_due = 1'b0;
    n = 0;
    while (!refresh_grant && !sched_ready && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(refresh_grant && !sched_ready, "R8 refresh before access",
        int'({refresh_grant, sched_ready}), 2);
    @(negedge clk);
    chk(!sched_ready && cke, "R10 access held during refresh",
        int'({sched_ready, cke}), 1);
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
    chk(sched_ready == 1'b1, "R8 access after refresh", int'(sched_ready), 1);
    @(negedge clk);
    acc_req  = 1'b0;
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule